// File: doc/BRIEF.md
# Packet-Driven Countdown Timer Endpoint

This block is a timer peripheral that occupies one endpoint of an on-chip mesh. It is set up only through 64-bit command packets on a valid/ready receive port. It reports only through 64-bit packets on a valid/ready transmit port. A reloadable down-counter sets the tick period. A mask bit turns tick notifications on or off. A binding register names the core that receives the ticks. An identify command returns a descriptor word that gives the device kind, the protocol version and a capability field.

Every packet uses the same field layout, from the least significant bit upward: destination tile (6 bits), source tile (6 bits), opcode (4 bits), flags (4 bits), payload (32 bits) and reserved (12 bits). The router decodes this layout. The block's own tile ID defaults to 0x20.

Replies leave through a small state machine with three states:

- IDLE: nothing is offered.
- SEND_TICK: a tick packet is offered.
- SEND_IDENT: an identify reply is offered.

The transitions are:

- IDLE→SEND_TICK when a tick is pending. This takes priority.
- IDLE→SEND_IDENT when an identify reply is pending and no tick is pending.
- SEND_TICK→IDLE and SEND_IDENT→IDLE on the transmit handshake.

While the transmit port is stalled, the state machine stays where it is.

Top module: `mesh_tick_timer`

## Requirements
- R1: After reset, tx_valid is 0 and rx_ready is 1. Ticks are disabled and the bound core is 0, so the first tick after enabling goes to core 0.
- R2: Every sent packet carries the block's tile ID (0x20) in bits [11:6] and zero in the flag bits [19:16] and the reserved bits [63:52].
- R3: Opcode 0x1 (bits [15:12]) loads payload bits [51:20] as both the reload value and the current count. With ticks enabled, the first tick is offered N+1 cycles after the accepting clock edge, and later ticks follow every N cycles.
- R4: A reload value of zero stops the counter, and no further ticks are produced.
- R5: Opcode 0x2 takes payload bit 0 as the tick enable (1 = enabled). While it is 0, expiries produce no packet. The counter keeps running, so ticks resume after it is set back to 1.
- R6: Opcode 0x4 binds ticks to the core given in payload bits [5:0]. A tick packet has destination = bound core, opcode 0x3 and payload = the bound core's ID.
- R7: Opcode 0xF (identify) produces a reply with the following properties:
  - its destination is the request's source tile;
  - its opcode is 0xF;
  - its payload is {kind 0x03, version 0x01, capabilities 0x0001}, holding bits [31:24], [23:16] and [15:0];
  - it is offered one cycle after the accepting edge.
- R8: rx_ready is 0 from the edge that accepts an identify until the edge that hands its reply over.
- R9: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_pkt does not change.
- R10: Any number of expiries during a transmit stall are merged into a single tick packet.
- R11: Packets with any other opcode, including 0x3, are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Command packet present |
| rx_ready | output | 1 | Block can accept a command |
| rx_pkt | input | 64 | Command packet |
| tx_valid | output | 1 | Reply or tick packet present |
| tx_ready | input | 1 | Mesh accepts the outgoing packet |
| tx_pkt | output | 64 | Reply or tick packet |

## Verification
The bench calls the edge that accepts a command E.

- Configuration commands take effect at E.
- An identify reply becomes visible after edge E+1.
- After a reload of N, the first tick becomes visible after edge E+N+1. Each later tick follows N edges after the previous one.

Inputs are driven and outputs sampled on the falling clock edge. The bench counts the falling edges from the one just after E up to the first one that shows tx_valid, and compares that count with 1, N+1 or N exactly. Stall and merge checks hold tx_ready low across several expiries. Each falling edge with tx_valid and tx_ready both high is then counted as one delivered packet.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
    localparam int TILE_W = 6;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 4;
    localparam int PL_W   = 32;
    localparam int RSVD_W = 12;
    localparam int PKT_W  = TILE_W * 2 + OP_W + FLAG_W + PL_W + RSVD_W;

    localparam logic [OP_W-1:0] OP_RELOAD = 4'h1;
    localparam logic [OP_W-1:0] OP_MASK   = 4'h2;
    localparam logic [OP_W-1:0] OP_TICK   = 4'h3;
    localparam logic [OP_W-1:0] OP_BIND   = 4'h4;
    localparam logic [OP_W-1:0] OP_IDENT  = 4'hF;

    localparam logic [7:0] KIND_TIMER = 8'h03;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic [PL_W-1:0]   pl;
        logic [FLAG_W-1:0] flag;
        logic [OP_W-1:0]   op;
        logic [TILE_W-1:0] src;
        logic [TILE_W-1:0] dst;
    } mtt_pkt_t;

    typedef struct packed {
        logic ld_reload;
        logic set_mask;
        logic set_bind;
        logic ident;
    } mtt_cmd_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_TICK,
        S_IDENT
    } mtt_state_e;
endpackage

// File: rtl/mtt_cmd_decode.sv
module mtt_cmd_decode
    import mtt_pkg::*;
(
    input  logic     fire,
    input  mtt_pkt_t pkt,
    output mtt_cmd_t cmd
);
    always_comb begin
        cmd = '0;
        if (fire) begin
            case (pkt.op)
                OP_RELOAD: cmd.ld_reload = 1'b1;
                OP_MASK:   cmd.set_mask  = 1'b1;
                OP_BIND:   cmd.set_bind  = 1'b1;
                OP_IDENT:  cmd.ident     = 1'b1;
                default:   cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/mtt_countdown.sv
module mtt_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;

    assign expire = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            reload_q <= load_val;
            cnt_q    <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= expire ? reload_q : cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/mtt_reply_fsm.sv
module mtt_reply_fsm
    import mtt_pkg::*;
#(
    parameter logic [TILE_W-1:0] TILE_ID = 6'h20,
    parameter logic [7:0]        VERSION = 8'h01,
    parameter logic [15:0]       CAPS    = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_req,
    input  logic              ident_req,
    input  logic [TILE_W-1:0] ident_src,
    input  logic [TILE_W-1:0] bound_core,
    input  logic              tx_ready,
    output logic              tx_valid,
    output mtt_pkt_t          tx_pkt,
    output logic              id_busy
);
    mtt_state_e        state_q, state_n;
    logic              tick_pend, id_pend;
    logic [TILE_W-1:0] id_src_q;
    mtt_pkt_t          pkt_q;
    logic              hs;

    assign tx_valid = (state_q != S_IDLE);
    assign tx_pkt   = pkt_q;
    assign id_busy  = id_pend;
    assign hs       = tx_valid && tx_ready;

    function automatic mtt_pkt_t make_pkt(input logic [TILE_W-1:0] dst,
                                          input logic [OP_W-1:0] op,
                                          input logic [PL_W-1:0] pl);
        mtt_pkt_t p;
        p      = '0;
        p.dst  = dst;
        p.src  = TILE_ID;
        p.op   = op;
        p.pl   = pl;
        return p;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_pend <= 1'b0;
            id_pend   <= 1'b0;
            id_src_q  <= '0;
        end else begin
            tick_pend <= tick_req || (tick_pend && !(hs && state_q == S_TICK));
            if (ident_req) begin
                id_pend  <= 1'b1;
                id_src_q <= ident_src;
            end else if (hs && state_q == S_IDENT) begin
                id_pend  <= 1'b0;
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (tick_pend)    state_n = S_TICK;
                else if (id_pend) state_n = S_IDENT;
            end
            S_TICK:  if (tx_ready) state_n = S_IDLE;
            S_IDENT: if (tx_ready) state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_q <= '0;
        end else if (state_q == S_IDLE) begin
            if (tick_pend)
                pkt_q <= make_pkt(bound_core, OP_TICK, PL_W'(bound_core));
            else if (id_pend)
                pkt_q <= make_pkt(id_src_q, OP_IDENT, {KIND_TIMER, VERSION, CAPS});
        end
    end
endmodule

// File: rtl/mesh_tick_timer.sv
module mesh_tick_timer
    import mtt_pkg::*;
#(
    parameter int                CNT_W   = 32,
    parameter logic [TILE_W-1:0] TILE_ID = 6'h20,
    parameter logic [7:0]        VERSION = 8'h01,
    parameter logic [15:0]       CAPS    = 16'h0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [63:0] rx_pkt,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [63:0] tx_pkt
);
    mtt_pkt_t          cmd_pkt, out_pkt;
    mtt_cmd_t          cmd;
    logic              fire, id_busy, expire;
    logic              en_q;
    logic [TILE_W-1:0] core_q;
    logic              unused_fields;

    assign cmd_pkt  = mtt_pkt_t'(rx_pkt);
    assign rx_ready = !id_busy;
    assign fire     = rx_valid && rx_ready;
    assign tx_pkt   = 64'(out_pkt);
    assign unused_fields = ^{cmd_pkt.rsvd, cmd_pkt.flag, cmd_pkt.dst, cmd_pkt.pl};

    mtt_cmd_decode u_dec (
        .fire (fire),
        .pkt  (cmd_pkt),
        .cmd  (cmd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            core_q <= '0;
        end else begin
            if (cmd.set_mask) en_q   <= cmd_pkt.pl[0];
            if (cmd.set_bind) core_q <= cmd_pkt.pl[TILE_W-1:0];
        end
    end

    mtt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd.ld_reload),
        .load_val (cmd_pkt.pl[CNT_W-1:0]),
        .expire   (expire)
    );

    mtt_reply_fsm #(
        .TILE_ID (TILE_ID),
        .VERSION (VERSION),
        .CAPS    (CAPS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_req   (expire && en_q),
        .ident_req  (cmd.ident),
        .ident_src  (cmd_pkt.src),
        .bound_core (core_q),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_pkt     (out_pkt),
        .id_busy    (id_busy)
    );
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
    parameter logic [5:0] TILE_ID = 6'h20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic [63:0] rx_pkt,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [63:0] tx_pkt
);
    logic rst_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n && rst_seen === 1'b1)
            assert_reset_quiet_R1: assert (!tx_valid && rx_ready);
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_pkt)));

    assert_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_pkt[11:6] == TILE_ID && tx_pkt[19:16] == 4'h0
                      && tx_pkt[63:52] == 12'h000));

    assert_ident_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_pkt[15:12] == 4'hF) |=> !rx_ready);

    assert_tick_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_pkt[15:12] == 4'h3) |-> (tx_pkt[51:20] == {26'b0, tx_pkt[5:0]}));
endmodule

bind mesh_tick_timer mtt_checker #(.TILE_ID(TILE_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_pkt   (rx_pkt),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_pkt   (tx_pkt)
);

// File: tb/mesh_tick_timer_test.sv
module mesh_tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [63:0] rx_pkt = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [63:0] tx_pkt;
    int          tests = 0;
    int          fails = 0;
    logic [63:0] held;

    always #4 clk = ~clk;

    mesh_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_pkt(rx_pkt), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_pkt(tx_pkt)
    );

    // stimulus: reload, core; expected: first-tick latency
    localparam int NV = 4;
    localparam int V_RELOAD [NV] = '{2, 5, 9, 17};
    localparam int V_CORE   [NV] = '{1, 7, 0, 63};
    localparam int V_LAT    [NV] = '{3, 6, 10, 18};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [31:0] pl, input logic [5:0] src);
        rx_pkt   = {12'h0, pl, 4'h0, op, src, 6'h20};
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_valid(output int k);
        k = 0;
        while (!tx_valid && k < 300) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic count_valid(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            if (tx_valid) n++;
            @(negedge clk);
        end
    endtask

    task automatic stop_and_drain();
        send(4'h1, 32'd0, 6'h01);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int k, n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 tx_valid in reset", 64'(tx_valid), 64'd0);
        check("R1 rx_ready in reset", 64'(rx_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: ticks disabled after reset, bound core 0
        send(4'h1, 32'd3, 6'h01);
        count_valid(20, n);
        check("R1 no tick while disabled", 64'(n), 64'd0);
        send(4'h2, 32'd1, 6'h01);
        wait_valid(k);
        check("R1 default core dst", 64'(tx_pkt[5:0]), 64'd0);
        stop_and_drain();

        // R7: identify
        send(4'hF, 32'd0, 6'h05);
        wait_valid(k);
        check("R7 ident latency", 64'(k), 64'd1);
        check("R7 ident dst", 64'(tx_pkt[5:0]), 64'h05);
        check("R7 ident op", 64'(tx_pkt[15:12]), 64'hF);
        check("R7 ident payload", 64'(tx_pkt[51:20]), 64'h0301_0001);
        check("R2 ident src/flag/rsvd", {tx_pkt[63:52], tx_pkt[19:16], tx_pkt[11:6]}, 64'h20);
        repeat (3) @(negedge clk);

        // R3/R6: vector table
        for (int v = 0; v < NV; v++) begin
            send(4'h4, 32'(V_CORE[v]), 6'h01);
            send(4'h2, 32'd1, 6'h01);
            send(4'h1, 32'(V_RELOAD[v]), 6'h01);
            wait_valid(k);
            check("R3 first tick latency", 64'(k), 64'(V_LAT[v]));
            check("R6 tick dst", 64'(tx_pkt[5:0]), 64'(V_CORE[v]));
            check("R6 tick op", 64'(tx_pkt[15:12]), 64'h3);
            check("R6 tick payload", 64'(tx_pkt[51:20]), 64'(V_CORE[v]));
            check("R2 tick src/flag/rsvd", {tx_pkt[63:52], tx_pkt[19:16], tx_pkt[11:6]}, 64'h20);
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!tx_valid && k < 300);
            check("R3 tick period", 64'(k), 64'(V_RELOAD[v]));
            stop_and_drain();
        end

        // R5: mask off suppresses, counter keeps running
        send(4'h4, 32'd2, 6'h01);
        send(4'h2, 32'd0, 6'h01);
        send(4'h1, 32'd4, 6'h01);
        count_valid(20, n);
        check("R5 masked no tick", 64'(n), 64'd0);
        send(4'h2, 32'd1, 6'h01);
        wait_valid(k);
        check("R5 tick resumes", 64'(k <= 5), 64'd1);
        stop_and_drain();

        // R11: unknown opcodes ignored
        send(4'h4, 32'd9, 6'h01);
        send(4'h7, 32'd3, 6'h01);
        send(4'h3, 32'd4, 6'h01);
        send(4'h0, 32'd5, 6'h01);
        count_valid(10, n);
        check("R11 no output on unknown op", 64'(n), 64'd0);
        send(4'h1, 32'd2, 6'h01);
        wait_valid(k);
        check("R11 binding unchanged", 64'(tx_pkt[5:0]), 64'd9);
        stop_and_drain();

        // R9/R10/R4: stall, merge, stop
        tx_ready = 1'b0;
        send(4'h4, 32'd4, 6'h01);
        send(4'h1, 32'd3, 6'h01);
        wait_valid(k);
        held = tx_pkt;
        repeat (12) @(negedge clk);
        check("R9 valid held", 64'(tx_valid), 64'd1);
        check("R9 packet stable", tx_pkt, held);
        send(4'h1, 32'd0, 6'h01);
        tx_ready = 1'b1;
        count_valid(20, n);
        check("R10 merged ticks", 64'(n), 64'd1);
        count_valid(20, n);
        check("R4 zero reload stops", 64'(n), 64'd0);

        // R8: rx_ready low while identify reply pending
        tx_ready = 1'b0;
        send(4'hF, 32'd0, 6'h03);
        check("R8 rx_ready low", 64'(rx_ready), 64'd0);
        wait_valid(k);
        check("R8 ident dst", 64'(tx_pkt[5:0]), 64'h03);
        tx_ready = 1'b1;
        @(negedge clk);
        check("R8 rx_ready restored", 64'(rx_ready), 64'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule